// File: doc/BRIEF.md
# Edge-Selectable Serial Command Receiver

This block takes command bytes from a host over a three-wire synchronous link (active-low chip select, serial clock, serial data) and presents each completed byte to the system clock domain. All three link inputs are oversampled by the system clock through synchronisers. A static phase input picks whether the serial data is captured on rising or on falling serial-clock edges.

Each completed byte produces a single-cycle valid strobe together with the byte value. The receiver also knows which opcodes carry one trailing data byte, and it marks that trailing byte so downstream command logic can tell opcodes from operands without keeping its own state.

Top module: `serial_cmd_rx`

## Requirements
- R1: Serial-clock edges are only counted while `csN` is low; edges seen while `csN` is high never produce a byte or shift bits.
- R2: Bits arrive most significant first; eight sampling edges form one byte whose first bit lands in `byteData[7]`.
- R3: With `edgeSel` = 0 data is captured on rising serial-clock edges; with `edgeSel` = 1 it is captured on falling edges.
- R4: `byteValid` is high for exactly one system cycle per completed byte, a few system cycles after the eighth sampling edge, and `byteData` holds that byte until the next one completes.
- R5: `csN` may stay low across any number of bytes; the bit counter wraps after every eighth edge so back-to-back bytes are all delivered.
- R6: Driving `csN` high returns the bit counter to zero and discards any partly received byte.
- R7: A byte whose upper four bits are 4'h4 or 4'h7 opens a data-byte expectation; the next completed byte is delivered with `secondByte` = 1 and never opens an expectation itself. `secondByte` is only ever high together with `byteValid`.
- R8: Driving `csN` high cancels a pending data-byte expectation.
- R9: An active-low asynchronous reset clears the shift register, the bit counter, the pending expectation and both output flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low link select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| edgeSel | input | 1 | Static capture-edge choice: 0 rising, 1 falling |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteData | output | 8 | Last completed byte |
| secondByte | output | 1 | Completed byte is the data byte of a two-byte command |

## Verification
The assertions rely on the serial clock being slow relative to the system clock, so that two sampling edges are always several system cycles apart and each serial-clock level lasts well beyond the synchroniser depth. They also assume `edgeSel` only changes while `csN` is high and data is stable around each sampling edge. The stimulus holds every serial-clock level for four system cycles, changes data only on the non-sampling edge, and switches the phase input and the idle clock level only with the link deselected.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef struct packed {
    logic shiftEn;   // capture one bit into the shift register
    logic byteDone;  // this bit completes a byte
    logic clearAll;  // link deselected: drop partial state
  } ctrlStrobe_t;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        edgeSel,
  output ctrlStrobe_t strobe,
  output logic        dataBit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic csSync, sclkSync, sclkPrev;
  logic riseSeen, fallSeen, sampleEdge, csActive;
  logic [CNT_W-1:0] bitCnt;

  scr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .d(csN), .q(csSync));
  scr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uClkSync (
    .clk(clk), .rstN(rstN), .d(sclk), .q(sclkSync));
  scr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uDatSync (
    .clk(clk), .rstN(rstN), .d(sdi), .q(dataBit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync;
  end

  assign riseSeen   = sclkSync & ~sclkPrev;
  assign fallSeen   = ~sclkSync & sclkPrev;
  assign sampleEdge = edgeSel ? fallSeen : riseSeen;
  assign csActive   = ~csSync;

  always_comb begin
    strobe.shiftEn  = csActive & sampleEdge;
    strobe.byteDone = csActive & sampleEdge & (bitCnt == LAST_BIT);
    strobe.clearAll = ~csActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bitCnt <= '0;
    else if (strobe.clearAll) bitCnt <= '0;
    else if (strobe.shiftEn)  bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                OPCODE_W  = 4,
  parameter logic [OPCODE_W-1:0] DATA_OP_A = 4'h4,
  parameter logic [OPCODE_W-1:0] DATA_OP_B = 4'h7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              dataBit,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              secondByte
);
  logic [BYTE_W-1:0]   shiftReg, nextByte;
  logic [OPCODE_W-1:0] opField;
  logic                opcodeHit, pending;

  assign nextByte  = {shiftReg[BYTE_W-2:0], dataBit};
  assign opField   = nextByte[BYTE_W-1 -: OPCODE_W];
  assign opcodeHit = (opField == DATA_OP_A) || (opField == DATA_OP_B);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      byteData   <= '0;
      byteValid  <= 1'b0;
      secondByte <= 1'b0;
      pending    <= 1'b0;
    end else begin
      byteValid  <= strobe.byteDone;
      secondByte <= strobe.byteDone & pending;
      if (strobe.clearAll) begin
        shiftReg <= '0;
        pending  <= 1'b0;
      end else if (strobe.shiftEn) begin
        shiftReg <= nextByte;
        if (strobe.byteDone) begin
          byteData <= nextByte;
          pending  <= pending ? 1'b0 : opcodeHit;
        end
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter int                  BYTE_W      = 8,
  parameter int                  OPCODE_W    = 4,
  parameter logic [OPCODE_W-1:0] DATA_OP_A   = 4'h4,
  parameter logic [OPCODE_W-1:0] DATA_OP_B   = 4'h7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              edgeSel,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              secondByte
);
  ctrlStrobe_t strobe;
  logic        dataBit;

  scr_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .edgeSel(edgeSel), .strobe(strobe), .dataBit(dataBit));

  scr_datapath #(.BYTE_W(BYTE_W), .OPCODE_W(OPCODE_W),
                 .DATA_OP_A(DATA_OP_A), .DATA_OP_B(DATA_OP_B)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataBit(dataBit),
    .byteValid(byteValid), .byteData(byteData), .secondByte(secondByte));
endmodule

// File: rtl/serial_cmd_rx_checker.sv
module serial_cmd_rx_checker #(
  parameter int                  BYTE_W    = 8,
  parameter int                  OPCODE_W  = 4,
  parameter logic [OPCODE_W-1:0] DATA_OP_A = 4'h4,
  parameter logic [OPCODE_W-1:0] DATA_OP_B = 4'h7
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              byteValid,
  input logic [BYTE_W-1:0] byteData,
  input logic              secondByte
);
  logic [BYTE_W-1:0] prevByte;
  logic              prevSecond;
  logic [OPCODE_W-1:0] prevOp;

  assign prevOp = prevByte[BYTE_W-1 -: OPCODE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevByte   <= '0;
      prevSecond <= 1'b0;
    end else if (byteValid) begin
      prevByte   <= byteData;
      prevSecond <= secondByte;
    end
  end

  // R4: the strobe never lasts two cycles
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R1: a deselected link produces no bytes
  p_idle_link_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4)) |-> !byteValid);

  // R7: data-byte flag only rides on a strobe
  p_second_qualified_r7: assert property (@(posedge clk) disable iff (!rstN)
    secondByte |-> byteValid);

  // R7: a flagged byte follows an unflagged data-carrying opcode
  p_second_after_opcode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && secondByte) |-> (!prevSecond && (prevOp == DATA_OP_A || prevOp == DATA_OP_B)));
endmodule

bind serial_cmd_rx serial_cmd_rx_checker #(
  .BYTE_W(BYTE_W), .OPCODE_W(OPCODE_W), .DATA_OP_A(DATA_OP_A), .DATA_OP_B(DATA_OP_B)
) uChecker (
  .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid),
  .byteData(byteData), .secondByte(secondByte));

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi, edgeSel;
  logic byteValid, secondByte;
  logic [7:0] byteData;

  int total = 0, fails = 0;
  int capCount = 0, widthErr = 0;
  logic [7:0] capData [0:1023];
  bit         capSec  [0:1023];
  logic prevValid = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_cmd_rx uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .edgeSel(edgeSel), .byteValid(byteValid), .byteData(byteData),
    .secondByte(secondByte));

  always @(negedge clk) begin
    if (rstN === 1'b1 && byteValid === 1'b1) begin
      if (capCount < 1024) begin
        capData[capCount] = byteData;
        capSec[capCount]  = secondByte;
      end
      capCount++;
      if (prevValid) widthErr++;
    end
    prevValid = (rstN === 1'b1) && (byteValid === 1'b1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic setPhase(input bit p);
    edgeSel = p;
    sclk = p;
    repeat (8) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = v[7-i];
      halfWait();
      sclk = ~sclk;
      halfWait();
      sclk = ~sclk;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    halfWait();
  endtask

  task automatic csHigh();
    halfWait();
    csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic expectByte(input int idx, input logic [7:0] v, input bit sec, input string req);
    check(capData[idx] == v, req, capData[idx], v);
    check(capSec[idx] == sec, req, capSec[idx], sec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int base;
    bit pend;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; edgeSel = 1'b0;
    repeat (5) @(negedge clk);
    check(byteValid == 1'b0, "R9 reset valid", byteValid, 0);
    check(secondByte == 1'b0, "R9 reset second", secondByte, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R5 R7: every byte value in one frame, both capture edges
    for (int p = 0; p < 2; p++) begin
      setPhase(p[0]);
      base = capCount;
      csLow();
      for (int v = 0; v < 256; v++) sendBits(v[7:0], 8);
      csHigh();
      check(capCount - base == 256, "R5 byte count", capCount - base, 256);
      pend = 0;
      for (int v = 0; v < 256; v++) begin
        expectByte(base + v, v[7:0], pend, p == 0 ? "R2 R3 rising" : "R2 R3 falling");
        pend = pend ? 1'b0 : (v[7:4] == 4'h4 || v[7:4] == 4'h7);
      end
    end
    check(widthErr == 0, "R4 strobe width", widthErr, 0);

    // R6: partial byte dropped by deselect
    setPhase(1'b0);
    base = capCount;
    csLow(); sendBits(8'hFF, 3); csHigh();
    csLow(); sendBits(8'h5A, 8); csHigh();
    check(capCount - base == 1, "R6 count", capCount - base, 1);
    expectByte(base, 8'h5A, 1'b0, "R6 realign");

    // R1: clocks while deselected
    base = capCount;
    sendBits(8'hA5, 8);
    sendBits(8'h3C, 5);
    repeat (10) @(negedge clk);
    check(capCount == base, "R1 ignored", capCount - base, 0);
    csLow(); sendBits(8'hC3, 8); csHigh();
    check(capCount - base == 1, "R1 count", capCount - base, 1);
    expectByte(base, 8'hC3, 1'b0, "R1 aligned");

    // R7: opcode / operand sequence
    base = capCount;
    csLow();
    sendBits(8'h71, 8); sendBits(8'h44, 8); sendBits(8'h47, 8); sendBits(8'h12, 8);
    csHigh();
    expectByte(base,     8'h71, 1'b0, "R7 opcode");
    expectByte(base + 1, 8'h44, 1'b1, "R7 operand");
    expectByte(base + 2, 8'h47, 1'b0, "R7 opcode2");
    expectByte(base + 3, 8'h12, 1'b1, "R7 operand2");

    // R8: deselect cancels expectation
    base = capCount;
    csLow(); sendBits(8'h40, 8); csHigh();
    csLow(); sendBits(8'h33, 8); csHigh();
    expectByte(base + 1, 8'h33, 1'b0, "R8 cancel");

    // R9: reset cancels expectation
    base = capCount;
    csLow(); sendBits(8'h7F, 8); csHigh();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(byteValid == 1'b0 && secondByte == 1'b0, "R9 reset flags", {byteValid, secondByte}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    csLow(); sendBits(8'h22, 8); csHigh();
    expectByte(base + 1, 8'h22, 1'b0, "R9 cancel");
    check(widthErr == 0, "R4 strobe width final", widthErr, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule